// File: doc/BRIEF.md
# MDIO Paged 32-bit Register Bridge

This block lets a 16-bit management-bus access path reach a 32-bit internal register space. It answers at one fixed PHY address and ignores all others. A page register holds the upper bits of the internal address. Sixteen window registers select a 32-bit word inside the current page and carry its low halfword. One further register carries that word's high halfword.

A 32-bit write takes three management accesses: page, low half, high half. The low-half write only stores the data and the word address. The high-half write then issues one internal write that combines both halves. A 32-bit read takes page, low half, high half. The low-half read performs the single internal read and keeps the upper halfword in a shadow register. The high-half read is then served from that shadow without touching the internal bus.

The bit-level serial shifter is outside this block. Its decoded accesses arrive as one-cycle read and write strobes with PHY address, register address and write data.

Top module: `mdio_page_bridge`

## Requirements
- R1: During and right after reset, the page, the latched word address, the low-half store and the high-half shadow are all zero, and `bus_we`, `bus_re` and `mdio_rvalid` are low.
- R2: A strobe whose PHY address is not 0x1F causes no internal bus access, no read response (`mdio_rvalid` stays low) and no change of any stored value.
- R3: Writing register 0x1F loads bits 9:0 of the write data into the page. Reading register 0x1F returns the page zero-extended to 16 bits.
- R4: Writing a register from 0x00 to 0x0F issues no internal access. It stores the write data as the pending low half and stores the word address {page, reg[3:0], 2'b00}.
- R5: Writing register 0x10 asserts `bus_we` for that one cycle. `bus_addr` is the stored word address and `bus_wdata` is {new data, stored low half}.
- R6: Reading a register from 0x00 to 0x0F asserts `bus_re` in the strobe cycle with `bus_addr` = {page, reg[3:0], 2'b00}. One cycle later `mdio_rdata` is `bus_rdata[15:0]`. Bits 31:16 go to the shadow, and the word address and low half are stored as well.
- R7: Reading register 0x10 returns the shadow and issues no internal access. The shadow changes only on a low-half read.
- R8: A page change between the low-half and high-half accesses does not move the high-half write. The write goes to the address stored by the low-half access.
- R9: Registers 0x11 to 0x1E ignore writes and read as zero.
- R10: When a write strobe and a read strobe arrive in the same cycle, only the write is performed. The read gets no response and has no effect.
- R11: `mdio_rvalid` is high for exactly one cycle, the cycle after an accepted read. `mdio_rdata` is zero whenever `mdio_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_wr_stb | input | 1 | Decoded management write strobe |
| mdio_rd_stb | input | 1 | Decoded management read strobe |
| mdio_phy | input | 5 | PHY address of the access |
| mdio_reg | input | 5 | Register address of the access |
| mdio_wdata | input | 16 | Write data |
| mdio_rdata | output | 16 | Read data, valid with mdio_rvalid |
| mdio_rvalid | output | 1 | Read response pulse |
| bus_addr | output | 16 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | Internal write enable |
| bus_re | output | 1 | Internal read enable |
| bus_rdata | input | 32 | Internal read data, valid in the same cycle as bus_re |

## Verification
Two functions can fall in the same cycle. A write strobe and a read strobe can coincide, and a read response can leave while a new strobe is accepted. The bench drives both strobes together toward a low-half register and the high register. The reference model predicts that only the write takes place, so no `bus_re` and no response follow. The bench also issues reads back-to-back and right after page writes, and checks that each response carries the data of its own access, including a page value written one cycle earlier.

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter logic [4:0] PHY_ADDR = 5'h1F,
  parameter logic [4:0] PAGE_REG = 5'h1F,
  parameter logic [4:0] HIGH_REG = 5'h10,
  parameter int         PAGE_W   = 10,
  localparam int        ADDR_W   = PAGE_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_wr_stb,
  input  logic              mdio_rd_stb,
  input  logic [4:0]        mdio_phy,
  input  logic [4:0]        mdio_reg,
  input  logic [15:0]       mdio_wdata,
  output logic [15:0]       mdio_rdata,
  output logic              mdio_rvalid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [31:0]       bus_rdata
);

  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       lo_q, hi_q;

  logic hit, wr_ok, rd_ok, lo_sel, hi_sel, pg_sel;
  logic [ADDR_W-1:0] win_addr;
  logic [15:0]       rd_mux;

  assign hit      = (mdio_phy == PHY_ADDR);
  assign wr_ok    = mdio_wr_stb & hit;
  assign rd_ok    = mdio_rd_stb & hit & ~mdio_wr_stb;
  assign lo_sel   = ~mdio_reg[4];
  assign hi_sel   = (mdio_reg == HIGH_REG);
  assign pg_sel   = (mdio_reg == PAGE_REG);
  assign win_addr = {page_q, mdio_reg[3:0], 2'b00};

  assign bus_re    = rd_ok & lo_sel;
  assign bus_we    = wr_ok & hi_sel;
  assign bus_addr  = bus_we ? addr_q : win_addr;
  assign bus_wdata = {mdio_wdata, lo_q};

  always_comb begin
    if (lo_sel)      rd_mux = bus_rdata[15:0];
    else if (hi_sel) rd_mux = hi_q;
    else if (pg_sel) rd_mux = 16'(page_q);
    else             rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q      <= '0;
      addr_q      <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      mdio_rvalid <= 1'b0;
      mdio_rdata  <= '0;
    end else begin
      mdio_rvalid <= rd_ok;
      mdio_rdata  <= rd_ok ? rd_mux : '0;
      if (wr_ok && pg_sel) page_q <= mdio_wdata[PAGE_W-1:0];
      if (wr_ok && lo_sel) begin
        addr_q <= win_addr;
        lo_q   <= mdio_wdata;
      end
      if (bus_re) begin
        addr_q <= win_addr;
        lo_q   <= bus_rdata[15:0];
        hi_q   <= bus_rdata[31:16];
      end
    end
  end

endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_wr_stb,
  input logic        mdio_rd_stb,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_rdata,
  input logic        mdio_rvalid,
  input logic        bus_we,
  input logic        bus_re,
  input logic [31:0] bus_rdata
);

  a_r2_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_phy != 5'h1F) |-> (!bus_we && !bus_re));

  a_r2_foreign_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_phy != 5'h1F) |=> !mdio_rvalid);

  a_r7_high_read_local: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_rd_stb && mdio_reg == 5'h10) |-> !bus_re);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_wr_stb && mdio_rd_stb) |-> (!bus_re ##1 !mdio_rvalid));

  a_r6_low_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> (mdio_rvalid && mdio_rdata == $past(bus_rdata[15:0])));

  a_r11_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_rvalid |-> (mdio_rdata == 16'h0));

  a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (mdio_wr_stb && !bus_re));

endmodule

bind mdio_page_bridge mdio_page_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_wr_stb(mdio_wr_stb), .mdio_rd_stb(mdio_rd_stb),
  .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_rdata(mdio_rdata),
  .mdio_rvalid(mdio_rvalid), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
);

// File: tb/mdio_page_bridge_test.sv
module mdio_page_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  phy = '0, rg = '0;
  logic [15:0] wd = '0;
  logic [15:0] mdio_rdata;
  logic        mdio_rvalid;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_we, bus_re;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] memval(logic [15:0] a);
    return {a ^ 16'hC3A5, ~a};
  endfunction

  assign bus_rdata = memval(bus_addr);

  mdio_page_bridge uut (
    .clk(clk), .rst_n(rst_n), .mdio_wr_stb(wr), .mdio_rd_stb(rd),
    .mdio_phy(phy), .mdio_reg(rg), .mdio_wdata(wd),
    .mdio_rdata(mdio_rdata), .mdio_rvalid(mdio_rvalid),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata)
  );

  int unsigned m_page = 0, m_addr = 0, m_lo = 0, m_hi = 0;
  bit          m_rv = 0;
  int unsigned m_rd = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, bit r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
    bit hit, wok, rok, e_we, e_re;
    int unsigned e_addr, win, word, resp;
    @(negedge clk);
    wr = w; rd = r; phy = p; rg = g; wd = d;
    #2;
    hit  = (p == 5'h1F);
    wok  = w && hit;
    rok  = r && hit && !w;
    win  = (m_page << 6) | (int'(g[3:0]) << 2);
    e_re = rok && (g < 5'h10);
    e_we = wok && (g == 5'h10);
    e_addr = e_we ? m_addr : win;
    chk(tag, "bus_we", bus_we, e_we);
    chk(tag, "bus_re", bus_re, e_re);
    if (e_we || e_re) chk(tag, "bus_addr", bus_addr, e_addr);
    if (e_we) chk(tag, "bus_wdata", bus_wdata, (longint'(d) << 16) | m_lo);
    chk(tag, "mdio_rvalid", mdio_rvalid, m_rv);
    chk(tag, "mdio_rdata", mdio_rdata, m_rv ? m_rd : 0);
    word = memval(16'(win));
    resp = 0;
    if (rok) begin
      if (g < 5'h10) resp = word & 32'hFFFF;
      else if (g == 5'h10) resp = m_hi;
      else if (g == 5'h1F) resp = m_page;
    end
    m_rv = rok;
    m_rd = resp;
    if (wok && g == 5'h1F) m_page = d & 32'h3FF;
    if (wok && g < 5'h10) begin m_addr = win; m_lo = d; end
    if (e_re) begin m_addr = win; m_lo = word & 32'hFFFF; m_hi = word >> 16; end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "bus_we", bus_we, 0);
    chk("R1", "bus_re", bus_re, 0);
    chk("R1", "mdio_rvalid", mdio_rvalid, 0);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, 1, 5'h1F, 5'h1F, 0);
    step("R1", 0, 1, 5'h1F, 5'h10, 0);
    step("R1", 0, 0, 5'h1F, 5'h00, 0);
    step("R3", 1, 0, 5'h1F, 5'h1F, 16'hFD55);
    step("R3", 0, 1, 5'h1F, 5'h1F, 0);
    step("R4", 1, 0, 5'h1F, 5'h03, 16'h1234);
    step("R5", 1, 0, 5'h1F, 5'h10, 16'hABCD);
    step("R6", 0, 1, 5'h1F, 5'h07, 0);
    step("R7", 0, 1, 5'h1F, 5'h10, 0);
    step("R7", 0, 1, 5'h1F, 5'h10, 0);
    step("R2", 1, 0, 5'h05, 5'h1F, 16'h0002);
    step("R2", 0, 1, 5'h00, 5'h04, 0);
    step("R2", 0, 1, 5'h1F, 5'h1F, 0);
    step("R8", 1, 0, 5'h1F, 5'h0C, 16'h5A5A);
    step("R8", 1, 0, 5'h1F, 5'h1F, 16'h0001);
    step("R8", 1, 0, 5'h1E, 5'h10, 16'h7777);
    step("R8", 1, 0, 5'h1F, 5'h10, 16'h9999);
    step("R9", 1, 0, 5'h1F, 5'h12, 16'hFFFF);
    step("R9", 0, 1, 5'h1F, 5'h12, 0);
    step("R9", 0, 1, 5'h1F, 5'h1E, 0);
    step("R10", 1, 1, 5'h1F, 5'h05, 16'h4321);
    step("R10", 1, 1, 5'h1F, 5'h10, 16'h8765);
    step("R10", 1, 1, 5'h1F, 5'h1F, 16'h0033);
    step("R11", 0, 1, 5'h1F, 5'h1F, 0);
    step("R11", 0, 1, 5'h1F, 5'h00, 0);
    step("R11", 0, 1, 5'h1F, 5'h0F, 0);
    step("R11", 0, 1, 5'h1F, 5'h10, 0);
    for (int i = 0; i < 40; i++) begin
      step("R6", 0, 1, 5'h1F, 5'(i % 16), 0);
      step("R5", 1, 0, 5'h1F, 5'h10, 16'(i * 3));
      step("R3", 1, 0, 5'h1F, 5'h1F, 16'(i * 37));
    end
    step("R11", 0, 0, 5'h1F, 5'h00, 0);
    step("R11", 0, 0, 5'h1F, 5'h00, 0);
    summary();
  end
endmodule